// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Word Interface

This block is the digital front end of a two-channel parallel-load converter. Each channel holds two words of `DATA_W` bits: a staging word that collects bus data, and an output word that drives the converter. A write strobe (active low), a load strobe (active high) and a two-bit channel address decide, once per clock, which channels change and how. The two strobes select one of four actions: stage, pass-through, commit, or hold. The address chooses channel A, channel B, both channels, or neither.

All three control pins and the data bus are sampled on a clock edge. The effect shows on the output words after the following edge. If the write strobe and the load strobe are wired together and driven as one low pulse, the pulse stages the bus word when it starts and commits it when it ends. An active-low reset clears both channels at once. After the reset is released, both words of both channels load a preset that a run-time pin selects: zero scale or midscale.

Top module: `dual_dac_regif`

## Requirements
- R1: The address is decoded as follows. `chan_addr_i` = 0 selects A, 1 selects no channel, 2 selects A and B, 3 selects B.
- R2: While `rst_ni` is low, both output words read zero, without waiting for a clock edge.
- R3: Three clock edges after `rst_ni` rises, the staging word and the output word of both channels hold the preset. The preset is 0 when `preset_mid_i` is 0, and only bit `DATA_W-1` set when it is 1.
- R4: Stage action (`wr_ni`=0, `ldac_i`=0): each selected staging word takes the bus, and the output words do not change.
- R5: Commit action (`wr_ni`=1, `ldac_i`=1): each selected output word copies its staging word, once, on the cycle the commit combination first appears. Holding the combination, or changing the address while it is held, causes no further copy.
- R6: Pass-through action (`wr_ni`=0, `ldac_i`=1): each selected channel loads the bus into both its staging word and its output word.
- R7: When both strobes are driven as one low pulse, the bus value at the start of the pulse reaches the selected output words when the pulse ends.
- R8: Hold action (`wr_ni`=1, `ldac_i`=0): no word changes, whatever the bus and the address do.
- R9: A channel that is not selected keeps both of its words, whatever the strobes do.
- R10: Pins sampled on one clock edge affect the output words on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preset_mid_i | input | 1 | Preset select applied after reset: 0 zero scale, 1 midscale |
| wr_ni | input | 1 | Write strobe, active low |
| ldac_i | input | 1 | Load strobe, active high |
| chan_addr_i | input | 2 | Channel address |
| data_i | input | DATA_W | Parallel data bus |
| dac_a_o | output | DATA_W | Output word of channel A |
| dac_b_o | output | DATA_W | Output word of channel B |

## Verification
A wrong output word is visible on the next edge after the action that produced it. A corrupted staging word stays hidden until a later commit copies it out. For this reason, stimulus always follows a stage action with a commit, and the result is compared one edge later. The random phase mixes addresses and strobe levels, including a held commit and address changes during a commit, so that an extra or missing copy appears as a mismatch on a channel that should have stayed still.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  // Encoding is {wr_n, ldac}.
  typedef enum logic [1:0] {
    MODE_STAGE = 2'b00,
    MODE_THRU  = 2'b01,
    MODE_HOLD  = 2'b10,
    MODE_COMMIT = 2'b11
  } mode_e;

  localparam int NUM_CH = 2;

  // Returns the channel mask {B, A}.
  function automatic logic [NUM_CH-1:0] chan_decode(input logic [1:0] addr);
    logic [NUM_CH-1:0] m;
    case (addr)
      2'd0:    m = 2'b01;
      2'd1:    m = 2'b00;
      2'd2:    m = 2'b11;
      default: m = 2'b10;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dacif_rst_sync.sv
module dacif_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic q1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1  <= 1'b0;
      run <= 1'b0;
    end else begin
      q1  <= 1'b1;
      run <= q1;
    end
  end
endmodule

// File: rtl/dacif_sampler.sv
module dacif_sampler
  import dacif_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              ldac,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] data,
  output mode_e             mode_q,
  output mode_e             mode_prev,
  output logic [NUM_CH-1:0] sel_q,
  output logic [DATA_W-1:0] data_q,
  output logic              commit_start
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_HOLD;
      mode_prev <= MODE_HOLD;
      sel_q     <= '0;
      data_q    <= '0;
    end else begin
      mode_q    <= mode_e'({wr_n, ldac});
      mode_prev <= mode_q;
      sel_q     <= chan_decode(addr);
      data_q    <= data;
    end
  end

  // A commit acts only on the cycle it first appears.
  assign commit_start = (mode_q == MODE_COMMIT) && (mode_prev != MODE_COMMIT);

endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
  import dacif_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset_ld,
  input  logic [DATA_W-1:0] preset_val,
  input  logic              sel,
  input  mode_e             mode,
  input  logic              commit_start,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] out_word
);
  logic [DATA_W-1:0] stage_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_word <= '0;
      out_word   <= '0;
    end else if (preset_ld) begin
      stage_word <= preset_val;
      out_word   <= preset_val;
    end else if (sel) begin
      case (mode)
        MODE_STAGE: stage_word <= data;
        MODE_THRU: begin
          stage_word <= data;
          out_word   <= data;
        end
        MODE_COMMIT: if (commit_start) out_word <= stage_word;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
  import dacif_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              preset_mid_i,
  input  logic              wr_ni,
  input  logic              ldac_i,
  input  logic [1:0]        chan_addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o
);
  localparam logic [DATA_W-1:0] MID_SCALE = {1'b1, {(DATA_W-1){1'b0}}};

  logic              run_w;
  mode_e             mode_q_w;
  mode_e             mode_prev_w;
  logic [NUM_CH-1:0] sel_w;
  logic [DATA_W-1:0] data_q_w;
  logic              commit_w;
  logic [DATA_W-1:0] preset_w;
  logic [DATA_W-1:0] word_w [NUM_CH];

  assign preset_w = preset_mid_i ? MID_SCALE : '0;

  dacif_rst_sync u_rst (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .run   (run_w)
  );

  dacif_sampler #(.DATA_W(DATA_W)) u_smp (
    .clk          (clk_i),
    .rst_n        (rst_ni),
    .wr_n         (wr_ni),
    .ldac         (ldac_i),
    .addr         (chan_addr_i),
    .data         (data_i),
    .mode_q       (mode_q_w),
    .mode_prev    (mode_prev_w),
    .sel_q        (sel_w),
    .data_q       (data_q_w),
    .commit_start (commit_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dacif_chan #(.DATA_W(DATA_W)) u_ch (
      .clk          (clk_i),
      .rst_n        (rst_ni),
      .preset_ld    (!run_w),
      .preset_val   (preset_w),
      .sel          (sel_w[g]),
      .mode         (mode_q_w),
      .commit_start (commit_w),
      .data         (data_q_w),
      .out_word     (word_w[g])
    );
  end

  assign dac_a_o = word_w[0];
  assign dac_b_o = word_w[1];

endmodule

// File: rtl/dacif_chk.sv
module dacif_chk
  import dacif_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input mode_e             mode_q,
  input mode_e             mode_prev,
  input logic [NUM_CH-1:0] sel,
  input logic [DATA_W-1:0] data_q,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b
);

  // R2
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert (dac_a == '0 && dac_b == '0)
        else $error("outputs not zero during reset");
    end
  end

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == MODE_HOLD) |=> ($stable(dac_a) && $stable(dac_b)));

  // R1
  no_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel == 2'b00) |=> ($stable(dac_a) && $stable(dac_b)));

  // R9
  b_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sel[1]) |=> $stable(dac_b));

  // R6
  a_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == MODE_THRU && sel[0]) |=> (dac_a == $past(data_q)));

  // R5
  commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == MODE_COMMIT && mode_prev == MODE_COMMIT)
      |=> ($stable(dac_a) && $stable(dac_b)));

endmodule

bind dual_dac_regif dacif_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_ni),
  .run       (run_w),
  .mode_q    (mode_q_w),
  .mode_prev (mode_prev_w),
  .sel       (sel_w),
  .data_q    (data_q_w),
  .dac_a     (dac_a_o),
  .dac_b     (dac_b_o)
);

// File: tb/sim_dual_dac_regif.sv
`timescale 1ns/1ps
module sim_dual_dac_regif;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         preset_mid;
  logic         wr_n;
  logic         ldac;
  logic [1:0]   addr;
  logic [W-1:0] data;
  logic [W-1:0] dac_a;
  logic [W-1:0] dac_b;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [W-1:0] m_stage [2];
  logic [W-1:0] m_out   [2];
  logic [1:0]   m_prev;

  always #5 clk = ~clk;

  dual_dac_regif #(.DATA_W(W)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .preset_mid_i (preset_mid),
    .wr_ni        (wr_n),
    .ldac_i       (ldac),
    .chan_addr_i  (addr),
    .data_i       (data),
    .dac_a_o      (dac_a),
    .dac_b_o      (dac_b)
  );

  function automatic logic [1:0] sel_of(input logic [1:0] a);
    case (a)
      2'd0: return 2'b01;
      2'd1: return 2'b00;
      2'd2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] ea, input logic [W-1:0] eb);
    tests++;
    if (dac_a !== ea || dac_b !== eb) begin
      fails++;
      $display("FAIL %s: actual a=%h b=%h expected a=%h b=%h", tag, dac_a, dac_b, ea, eb);
    end
  endtask

  task automatic check_model(input string tag);
    check(tag, m_out[0], m_out[1]);
  endtask

  // Called at a falling edge; holds the pins for two cycles.
  task automatic op(input logic w, input logic l, input logic [1:0] a, input logic [W-1:0] d);
    logic [1:0] mode;
    logic [1:0] s;
    wr_n = w; ldac = l; addr = a; data = d;
    mode = {w, l};
    s = sel_of(a);
    for (int c = 0; c < 2; c++) begin
      if (s[c]) begin
        case (mode)
          2'b00: m_stage[c] = d;
          2'b01: begin m_stage[c] = d; m_out[c] = d; end
          2'b11: if (m_prev != 2'b11) m_out[c] = m_stage[c];
          default: ;
        endcase
      end
    end
    m_prev = mode;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic p);
    logic [W-1:0] pv;
    pv = p ? {1'b1, {(W-1){1'b0}}} : '0;
    wr_n = 1'b1; ldac = 1'b0; addr = 2'd1; preset_mid = p;
    rst_n = 1'b0;
    #1;
    check("R2 reset immediate", '0, '0);
    @(negedge clk);
    @(negedge clk);
    check("R2 reset held", '0, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      m_stage[c] = pv;
      m_out[c]   = pv;
    end
    m_prev = 2'b10;
    check("R3 preset after release", pv, pv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] ra;
    logic       rw, rl;
    void'($urandom(32'd1234));
    rst_n = 1'b0; preset_mid = 1'b0; wr_n = 1'b1; ldac = 1'b0; addr = 2'd1; data = '0;
    @(negedge clk);
    do_reset(1'b0);

    op(1'b0, 1'b0, 2'd0, 16'h1234);
    check_model("R4 stage leaves output");
    op(1'b1, 1'b1, 2'd0, 16'hFFFF);
    check("R5 commit to A", 16'h1234, 16'h0000);
    op(1'b1, 1'b1, 2'd2, 16'hFFFF);
    check("R5 held commit no copy", 16'h1234, 16'h0000);
    op(1'b0, 1'b0, 2'd3, 16'h0BEE);
    op(1'b1, 1'b1, 2'd0, 16'h0000);
    check("R1 R9 addr0 commits A only", 16'h1234, 16'h0000);
    op(1'b1, 1'b0, 2'd2, 16'h7777);
    op(1'b1, 1'b1, 2'd3, 16'h0000);
    check("R1 addr3 commits B", 16'h1234, 16'h0BEE);
    op(1'b0, 1'b1, 2'd2, 16'hABCD);
    check("R6 thru both", 16'hABCD, 16'hABCD);
    op(1'b1, 1'b0, 2'd2, 16'h5A5A);
    check("R8 hold", 16'hABCD, 16'hABCD);
    op(1'b0, 1'b1, 2'd1, 16'h2222);
    check("R1 addr1 none", 16'hABCD, 16'hABCD);
    op(1'b0, 1'b0, 2'd3, 16'h0F0F);
    check("R7 pulse start", 16'hABCD, 16'hABCD);
    op(1'b1, 1'b1, 2'd3, 16'h9999);
    check("R7 pulse end", 16'hABCD, 16'h0F0F);

    do_reset(1'b1);
    op(1'b1, 1'b1, 2'd2, 16'h0000);
    check("R3 midscale survives commit", 16'h8000, 16'h8000);

    for (int i = 0; i < 400; i++) begin
      ra = 2'($urandom_range(0, 3));
      rw = 1'($urandom_range(0, 1));
      rl = 1'($urandom_range(0, 1));
      op(rw, rl, ra, W'($urandom));
      check_model("R10 random");
      if (i == 200) begin
        do_reset(1'($urandom_range(0, 1)));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule